// File: doc/BRIEF.md
# Expansion Module Interrupt Collector

This block gathers the interrupt lines of three expansion modules into one processor interrupt request. Each module line is active-low and asynchronous. It passes through a two-flop synchronizer and then sets a pending latch for that channel. The processor interrupt is high while any channel is pending.

Software controls each channel through one arm bit in a write-only control register. While a channel's arm bit is low, its latch is held clear and the channel cannot be set. Writing the bit high arms the channel for the next interrupt. Servicing a channel therefore takes two writes to the same register. The first write drops the bit to clear the latch. The second write raises the bit again to re-arm the channel. A read-only status word shows which channels are pending.

Top module: `modirq_collect`

## Requirements
- R1: After reset, the status word is 0, the processor interrupt is low and every channel is disarmed.
- R2: A module line is active when low. An active level that is driven just after an edge reaches the status word on the third rising clock edge, and not earlier.
- R3: While a channel's arm bit is 0, the channel's pending bit stays 0 and its module line is ignored.
- R4: An armed channel whose synchronized line is active becomes pending. It stays pending after the line is released, for as long as the channel stays armed.
- R5: The arm bit of channel n sits at control bit n+1 (control bits 3..1). Control bit 0 and bits 7..4 have no effect. A write that drops an arm bit clears that channel's pending bit on the clock edge after the write edge.
- R6: Re-arming a channel whose module line is still active makes the channel pending again. Re-arming a channel whose line has been released leaves it clear.
- R7: Status bits 2..0 hold the pending bits of channels 2..0, and status bits 7..3 read 0.
- R8: The processor interrupt is high exactly when at least one status bit is set.
- R9: Each channel is independent. Clearing or arming one channel leaves the pending state of the other channels unchanged.
- R10: Writing 0x0C and then 0x0E clears channel 0 and then re-arms it. Channels 1 and 2 stay armed throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_irq_n_i | input | 3 | Active-low module interrupt lines, one per channel |
| ctl_wr_i | input | 1 | Write strobe for the control register |
| ctl_wdata_i | input | 8 | Control write data; the arm bits are at bits 3..1 |
| stat_rd_data_o | output | 8 | Status word; the pending bits are at bits 2..0 |
| cpu_irq_o | output | 1 | Processor interrupt request |

## Verification
The bench measures the synchronizer latency to the exact edge. A design with one stage too few or too many shows the pending bit one cycle early or late. The bench drives module lines while the channels are disarmed, and it writes words that set only the unused control bits. A latch that is not held in reset, or an arm field at the wrong offset, would then raise a status bit. The bench re-arms a channel both with its line still active and with its line released. An edge-triggered latch would miss the first case, and a latch that is not cleared would stay set in the second. A random phase mixes line levels with control writes against a model that tracks arm and pending bits per channel. This phase catches crosstalk between channels and lost pending state.

// File: rtl/modirq_pkg.sv
package modirq_pkg;
    localparam int NUM_CH      = 3;
    localparam int REG_W       = 8;
    localparam int ACK_LSB     = 1;
    localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/modirq_sync.sv
module modirq_sync #(
    parameter int W      = modirq_pkg::NUM_CH,
    parameter int STAGES = modirq_pkg::SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] req_n_i,
    output logic [W-1:0] req_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0] = ~req_n_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.stg[s] = st_q.stg[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o = st_q.stg[STAGES-1];

    // A first-stage bit may only rise after its line was seen low
    assert_first_stage_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.stg[0] & ~$past(st_q.stg[0])) & $past(req_n_i)) == '0);
endmodule

// File: rtl/modirq_ack_reg.sv
module modirq_ack_reg #(
    parameter int NUM_CH  = modirq_pkg::NUM_CH,
    parameter int REG_W   = modirq_pkg::REG_W,
    parameter int ACK_LSB = modirq_pkg::ACK_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [NUM_CH-1:0] arm_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] arm;
    } ack_st_t;

    ack_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) st_d.arm = wdata_i[ACK_LSB +: NUM_CH];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign arm_o = st_q.arm;

    assert_ack_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(st_q.arm));

    assert_ack_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (st_q.arm == $past(wdata_i[ACK_LSB +: NUM_CH])));
endmodule

// File: rtl/modirq_chan_latch.sv
module modirq_chan_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic arm_i,
    output logic pend_o
);
    typedef struct packed {
        logic pend;
    } latch_st_t;

    latch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!arm_i)     st_d.pend = 1'b0;
        else if (req_i) st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    assert_disarmed_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_i |=> !st_q.pend);

    assert_set_needs_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.pend) |-> $past(req_i && arm_i));

    assert_hold_while_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && arm_i) |=> st_q.pend);
endmodule

// File: rtl/modirq_collect.sv
module modirq_collect #(
    parameter int NUM_CH      = modirq_pkg::NUM_CH,
    parameter int REG_W       = modirq_pkg::REG_W,
    parameter int ACK_LSB     = modirq_pkg::ACK_LSB,
    parameter int SYNC_STAGES = modirq_pkg::SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] mod_irq_n_i,
    input  logic              ctl_wr_i,
    input  logic [REG_W-1:0]  ctl_wdata_i,
    output logic [REG_W-1:0]  stat_rd_data_o,
    output logic              cpu_irq_o
);
    localparam int PAD_W = REG_W - NUM_CH;

    logic [NUM_CH-1:0] req_sync;
    logic [NUM_CH-1:0] arm;
    logic [NUM_CH-1:0] pend;

    modirq_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_n_i (mod_irq_n_i),
        .req_o   (req_sync)
    );

    modirq_ack_reg #(.NUM_CH(NUM_CH), .REG_W(REG_W), .ACK_LSB(ACK_LSB)) u_ack (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (ctl_wr_i),
        .wdata_i (ctl_wdata_i),
        .arm_o   (arm)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        modirq_chan_latch u_latch (
            .clk    (clk),
            .rst_n  (rst_n),
            .req_i  (req_sync[c]),
            .arm_i  (arm[c]),
            .pend_o (pend[c])
        );
    end

    assign stat_rd_data_o = {{PAD_W{1'b0}}, pend};
    assign cpu_irq_o      = |pend;

    assert_irq_off_when_disarmed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(arm) == '0) |-> !cpu_irq_o);
endmodule

// File: tb/modirq_collect_tb.sv
`timescale 1ns/1ps
module modirq_collect_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mod_irq_n = 3'b111;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic [7:0] stat;
    logic       irq;

    int n_checks = 0;
    int n_fails  = 0;
    logic [2:0] exp_arm  = 3'b000;
    logic [2:0] exp_pend = 3'b000;

    always #2.5 clk = ~clk;

    modirq_collect u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .mod_irq_n_i    (mod_irq_n),
        .ctl_wr_i       (ctl_wr),
        .ctl_wdata_i    (ctl_wdata),
        .stat_rd_data_o (stat),
        .cpu_irq_o      (irq)
    );

    function automatic logic [2:0] arm_of(input logic [7:0] w);
        return w[3:1];
    endfunction

    function automatic logic [2:0] next_pend(input logic [2:0] arm, input logic [2:0] old,
                                             input logic [2:0] act);
        return arm & (old | act);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_out(input string req, input logic [2:0] p);
        check(req, {24'd0, stat}, {29'd0, p});
        check(req, {31'd0, irq}, {31'd0, |p});
    endtask

    task automatic do_write(input logic [7:0] v);
        @(negedge clk);
        ctl_wr = 1'b1;
        ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 1'b0;
        ctl_wdata = 8'h00;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #200000;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        idle(3);
        rst_n = 1'b1;
        idle(1);
        check_out("R1 reset", 3'b000);

        mod_irq_n = 3'b000;
        idle(6);
        check_out("R3 disarmed ignore", 3'b000);
        mod_irq_n = 3'b111;
        idle(4);

        do_write(8'h0E);
        idle(5);
        check_out("R6 arm released", 3'b000);

        mod_irq_n = 3'b101;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R2 not before third edge", {29'd0, stat[2:0]}, 32'd0);
        @(negedge clk);
        check_out("R2 third edge", 3'b010);

        mod_irq_n = 3'b111;
        idle(6);
        check_out("R4 hold after release", 3'b010);

        mod_irq_n = 3'b110;
        idle(5);
        check_out("R9 two pending", 3'b011);
        do_write(8'h0A);
        check("R5 latency hold", {29'd0, stat[2:0]}, 32'd3);
        @(negedge clk);
        check_out("R9 clear one keeps other", 3'b001);

        do_write(8'h0E);
        idle(3);
        do_write(8'h0C);
        idle(3);
        check_out("R10 clear ch0", 3'b000);
        do_write(8'h0E);
        idle(4);
        check_out("R6 rearm while active", 3'b001);
        mod_irq_n = 3'b111;
        do_write(8'h0C);
        do_write(8'h0E);
        idle(5);
        check_out("R10 rearm after release", 3'b000);

        mod_irq_n = 3'b101;
        idle(5);
        check_out("R10 ch1 still armed", 3'b010);

        do_write(8'hF1);
        mod_irq_n = 3'b000;
        idle(6);
        check_out("R5 unused bits no effect", 3'b000);
        do_write(8'hFF);
        idle(5);
        check_out("R7 all pending", 3'b111);
        check("R7 upper bits zero", {27'd0, stat[7:3]}, 32'd0);

        exp_arm = 3'b111;
        exp_pend = 3'b111;
        for (int k = 0; k < 200; k++) begin
            logic [2:0] lines;
            logic [7:0] w;
            lines = 3'($urandom_range(0, 7));
            w = 8'($urandom_range(0, 255));
            mod_irq_n = lines;
            if ($urandom_range(0, 3) != 0) begin
                do_write(w);
                exp_arm = arm_of(w);
            end
            idle(5);
            exp_pend = next_pend(exp_arm, exp_pend, ~lines);
            check_out("R9 random", exp_pend);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule